// File: doc/BRIEF.md
# Memory Fault Syndrome Capture

This block holds the syndrome of the most recent address-translation fault, so that trap software can find out what went wrong. When the data-side translator reports a fault, the block stores the faulting virtual address. It also stores a packed status word, made from the instruction opcode, the destination register number and six fault flags. A third register receives a formatted page-table-entry address. When the instruction-side translator reports a fault, the block stores the faulting PC and a formatted page-table-entry address for it. Deciding which flags apply belongs to the translator. The block only packs the flags it is given.

After a data fault is captured, the data-side registers lock. The first fault's syndrome then survives later faults until software reads the captured data VA through the read port. The lock is held by a two-state machine. In state OPEN a data fault is accepted. The capture transition moves OPEN to HELD. In HELD, data faults are dropped unless a VA read happens in the same cycle. The release transition (a VA read with no fault) moves HELD back to OPEN. The recapture transition (a VA read together with a fault) stays in HELD and stores the new fault. Faults flagged as speculative change nothing on either side.

Top module: `fault_syndrome_regs`

## Requirements
- R1: Reset (rst_n low) clears all five captured registers and the data lock (data_locked = 0).
- R2: A non-speculative data fault (dflt_valid=1, dflt_spec=0) while unlocked stores dflt_va and sets data_locked; the values are readable after the next rising clock edge.
- R3: The data status word is {dflt_opcode[5:0] in bits 16:11, dflt_ra[4:0] in bits 10:6, dflt_flags[5:0] in bits 5:0}, zero-extended to the read width. The flag bits are 0 write, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 translation miss, 5 bad virtual address.
- R4: A formatted address is base OR ((address >> PG_SHIFT) << 3), truncated to VA_W bits. The data side uses dpte_base with the data VA. The instruction side uses ipte_base with the PC.
- R5: While locked, a data fault without a same-cycle VA read changes none of the data VA, status and formatted address.
- R6: A read (csr_rd_en=1) with selector 0 (data VA) and no accepted fault clears the lock. A read of any other selector leaves the lock unchanged.
- R7: A VA read and a non-speculative data fault in the same cycle release the lock and capture the new fault, and the lock stays set.
- R8: A fault with its speculative flag set updates no register and does not set the lock, on either side.
- R9: A non-speculative instruction fault always stores iflt_pc in the tag register and its formatted address. The instruction side has no lock.
- R10: The read selector codes are: 0 data VA, 1 data status, 2 data formatted address, 3 instruction tag, 4 instruction formatted address. Codes 5 to 7 read as zero. Read data follows csr_rd_sel combinationally, whether or not csr_rd_en is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dflt_valid | input | 1 | Data translation fault this cycle |
| dflt_spec | input | 1 | Data fault belongs to a misspeculated request |
| dflt_va | input | VA_W | Faulting data virtual address |
| dflt_opcode | input | 6 | Opcode of the faulting instruction |
| dflt_ra | input | 5 | Destination register number of the faulting instruction |
| dflt_flags | input | 6 | Fault flags chosen by the translator |
| dpte_base | input | VA_W | Data page-table base for the formatted address |
| iflt_valid | input | 1 | Instruction translation fault this cycle |
| iflt_spec | input | 1 | Instruction fault belongs to a misspeculated fetch |
| iflt_pc | input | VA_W | Faulting PC |
| ipte_base | input | VA_W | Instruction page-table base for the formatted address |
| csr_rd_en | input | 1 | Read strobe (a read of selector 0 releases the lock) |
| csr_rd_sel | input | 3 | Register selector |
| csr_rd_data | output | VA_W | Selected register contents |
| data_locked | output | 1 | Data-side lock state |

## Verification
Every capture, and every lock change, is due at the first rising edge after the stimulus is presented. It is visible at the ports one time unit after that edge. Read data is combinational, so it is due in the same cycle as the selector. The bench drives each stimulus just after an edge. It advances exactly one edge, then with csr_rd_en low it steps the selector through all five registers and compares each against a model that applies the lock, release and recapture rules of that same edge. Because peeks with the strobe low cause no release, observation never disturbs the lock.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
    localparam int OPC_W  = 6;
    localparam int RA_W   = 5;
    localparam int FLG_W  = 6;
    localparam int STAT_W = OPC_W + RA_W + FLG_W;
    localparam int SEL_W  = 3;

    typedef enum logic [0:0] {
        DS_OPEN = 1'b0,
        DS_HELD = 1'b1
    } dlock_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_DVA   = 3'd0,
        SEL_DSTAT = 3'd1,
        SEL_DFMT  = 3'd2,
        SEL_ITAG  = 3'd3,
        SEL_IFMT  = 3'd4
    } csr_sel_e;
endpackage

// File: rtl/fsyn_fmt_addr.sv
module fsyn_fmt_addr #(
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13
) (
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] addr,
    output logic [VA_W-1:0] fmt
);
    localparam int ENTRY_SHIFT = 3;

    logic [VA_W-1:0] page_num;

    always_comb begin
        page_num = addr >> PG_SHIFT;
        fmt      = base | (page_num << ENTRY_SHIFT);
    end
endmodule

// File: rtl/fsyn_data_capture.sv
module fsyn_data_capture
    import fsyn_pkg::*;
#(
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_spec,
    input  logic [VA_W-1:0]   flt_va,
    input  logic [OPC_W-1:0]  flt_opcode,
    input  logic [RA_W-1:0]   flt_ra,
    input  logic [FLG_W-1:0]  flt_flags,
    input  logic [VA_W-1:0]   pte_base,
    input  logic              va_read,
    output logic [VA_W-1:0]   va_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [VA_W-1:0]   fmt_q,
    output logic              locked
);
    dlock_state_e    state_q, state_d;
    logic            take;
    logic            capture;
    logic [VA_W-1:0] fmt_new;

    assign take = flt_valid && !flt_spec;

    fsyn_fmt_addr #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_dfmt (
        .base (pte_base),
        .addr (flt_va),
        .fmt  (fmt_new)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_OPEN;
        else        state_q <= state_d;
    end

    // next state and capture enable
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            DS_OPEN: begin
                if (take) begin
                    state_d = DS_HELD;
                    capture = 1'b1;
                end
            end
            DS_HELD: begin
                if (va_read) begin
                    capture = take;
                    state_d = take ? DS_HELD : DS_OPEN;
                end
            end
            default: state_d = DS_OPEN;
        endcase
    end

    // captured registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            stat_q <= '0;
            fmt_q  <= '0;
        end else if (capture) begin
            va_q   <= flt_va;
            stat_q <= {flt_opcode, flt_ra, flt_flags};
            fmt_q  <= fmt_new;
        end
    end

    assign locked = (state_q == DS_HELD);

    // R2
    open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_OPEN && flt_valid && !flt_spec) |=> (va_q == $past(flt_va)) && locked);

    // R5
    held_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_HELD && !va_read) |=> $stable(va_q) && $stable(stat_q) && $stable(fmt_q) && locked);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_HELD && va_read && !(flt_valid && !flt_spec)) |=> !locked && $stable(va_q));

    // R7
    recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_HELD && va_read && flt_valid && !flt_spec) |=> locked && (va_q == $past(flt_va)));

    // R8
    dspec_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_spec) |=> $stable(va_q) && $stable(stat_q) && $stable(fmt_q));
endmodule

// File: rtl/fsyn_inst_capture.sv
module fsyn_inst_capture #(
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flt_valid,
    input  logic            flt_spec,
    input  logic [VA_W-1:0] flt_pc,
    input  logic [VA_W-1:0] pte_base,
    output logic [VA_W-1:0] tag_q,
    output logic [VA_W-1:0] fmt_q
);
    logic [VA_W-1:0] fmt_new;

    fsyn_fmt_addr #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_ifmt (
        .base (pte_base),
        .addr (flt_pc),
        .fmt  (fmt_new)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            fmt_q <= '0;
        end else if (flt_valid && !flt_spec) begin
            tag_q <= flt_pc;
            fmt_q <= fmt_new;
        end
    end

    // R9
    itag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_spec) |=> (tag_q == $past(flt_pc)));

    // R8
    ispec_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_spec) |=> $stable(tag_q) && $stable(fmt_q));
endmodule

// File: rtl/fsyn_read_mux.sv
module fsyn_read_mux
    import fsyn_pkg::*;
#(
    parameter int VA_W = 43
) (
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [VA_W-1:0]   dva,
    input  logic [STAT_W-1:0] dstat,
    input  logic [VA_W-1:0]   dfmt,
    input  logic [VA_W-1:0]   itag,
    input  logic [VA_W-1:0]   ifmt,
    output logic [VA_W-1:0]   rd_data,
    output logic              va_read
);
    localparam int PAD_W = VA_W - STAT_W;

    always_comb begin
        case (rd_sel)
            SEL_DVA:   rd_data = dva;
            SEL_DSTAT: rd_data = {{PAD_W{1'b0}}, dstat};
            SEL_DFMT:  rd_data = dfmt;
            SEL_ITAG:  rd_data = itag;
            SEL_IFMT:  rd_data = ifmt;
            default:   rd_data = '0;
        endcase
    end

    assign va_read = rd_en && (rd_sel == SEL_DVA);

    // R10
    always_comb begin
        if (rd_sel > SEL_IFMT) begin
            unused_sel_zero_chk: assert (rd_data == '0);
        end
    end
endmodule

// File: rtl/fault_syndrome_regs.sv
module fault_syndrome_regs
    import fsyn_pkg::*;
#(
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dflt_valid,
    input  logic              dflt_spec,
    input  logic [VA_W-1:0]   dflt_va,
    input  logic [OPC_W-1:0]  dflt_opcode,
    input  logic [RA_W-1:0]   dflt_ra,
    input  logic [FLG_W-1:0]  dflt_flags,
    input  logic [VA_W-1:0]   dpte_base,
    input  logic              iflt_valid,
    input  logic              iflt_spec,
    input  logic [VA_W-1:0]   iflt_pc,
    input  logic [VA_W-1:0]   ipte_base,
    input  logic              csr_rd_en,
    input  logic [SEL_W-1:0]  csr_rd_sel,
    output logic [VA_W-1:0]   csr_rd_data,
    output logic              data_locked
);
    logic [VA_W-1:0]   dva_q, dfmt_q, itag_q, ifmt_q;
    logic [STAT_W-1:0] dstat_q;
    logic              va_read;

    fsyn_data_capture #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_valid  (dflt_valid),
        .flt_spec   (dflt_spec),
        .flt_va     (dflt_va),
        .flt_opcode (dflt_opcode),
        .flt_ra     (dflt_ra),
        .flt_flags  (dflt_flags),
        .pte_base   (dpte_base),
        .va_read    (va_read),
        .va_q       (dva_q),
        .stat_q     (dstat_q),
        .fmt_q      (dfmt_q),
        .locked     (data_locked)
    );

    fsyn_inst_capture #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_inst (
        .clk       (clk),
        .rst_n     (rst_n),
        .flt_valid (iflt_valid),
        .flt_spec  (iflt_spec),
        .flt_pc    (iflt_pc),
        .pte_base  (ipte_base),
        .tag_q     (itag_q),
        .fmt_q     (ifmt_q)
    );

    fsyn_read_mux #(.VA_W(VA_W)) u_mux (
        .rd_en   (csr_rd_en),
        .rd_sel  (csr_rd_sel),
        .dva     (dva_q),
        .dstat   (dstat_q),
        .dfmt    (dfmt_q),
        .itag    (itag_q),
        .ifmt    (ifmt_q),
        .rd_data (csr_rd_data),
        .va_read (va_read)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> !data_locked && (dva_q == '0) && (itag_q == '0));
endmodule

// File: tb/test_fault_syndrome_regs.sv
module test_fault_syndrome_regs;
    localparam int VA_W = 20;
    localparam int PG   = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dflt_valid, dflt_spec, iflt_valid, iflt_spec, csr_rd_en;
    logic [VA_W-1:0] dflt_va, dpte_base, iflt_pc, ipte_base, csr_rd_data;
    logic [5:0]      dflt_opcode, dflt_flags;
    logic [4:0]      dflt_ra;
    logic [2:0]      csr_rd_sel;
    logic            data_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the captured state
    logic [VA_W-1:0] m_dva, m_dstat, m_dfmt, m_itag, m_ifmt;
    logic            m_lock;

    always #5 clk = ~clk;

    fault_syndrome_regs #(.VA_W(VA_W), .PG_SHIFT(PG)) i_fault_syndrome_regs (
        .clk(clk), .rst_n(rst_n),
        .dflt_valid(dflt_valid), .dflt_spec(dflt_spec), .dflt_va(dflt_va),
        .dflt_opcode(dflt_opcode), .dflt_ra(dflt_ra), .dflt_flags(dflt_flags),
        .dpte_base(dpte_base),
        .iflt_valid(iflt_valid), .iflt_spec(iflt_spec), .iflt_pc(iflt_pc),
        .ipte_base(ipte_base),
        .csr_rd_en(csr_rd_en), .csr_rd_sel(csr_rd_sel),
        .csr_rd_data(csr_rd_data), .data_locked(data_locked)
    );

    task automatic chk(input string req, input logic [VA_W-1:0] got, input logic [VA_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [VA_W-1:0] fmt_of(input logic [VA_W-1:0] b, input logic [VA_W-1:0] a);
        logic [VA_W-1:0] pn;
        pn = a / (1 << PG);
        return b | VA_W'(pn * 8);
    endfunction

    // peek every register with the strobe low (no side effect)
    task automatic peek_all();
        csr_rd_en = 1'b0;
        csr_rd_sel = 3'd0; #1 chk("R2/R5 data VA", csr_rd_data, m_dva);
        csr_rd_sel = 3'd1; #1 chk("R3 data status", csr_rd_data, m_dstat);
        csr_rd_sel = 3'd2; #1 chk("R4 data fmt", csr_rd_data, m_dfmt);
        csr_rd_sel = 3'd3; #1 chk("R9 inst tag", csr_rd_data, m_itag);
        csr_rd_sel = 3'd4; #1 chk("R4/R9 inst fmt", csr_rd_data, m_ifmt);
        chk("R6/R7 lock", VA_W'(data_locked), VA_W'(m_lock));
    endtask

    // present one cycle of stimulus, advance one edge, check
    task automatic apply(input bit dv, input bit ds, input logic [VA_W-1:0] va,
                         input logic [5:0] op, input logic [4:0] ra, input logic [5:0] fl,
                         input bit iv, input bit is, input logic [VA_W-1:0] pc,
                         input bit en, input logic [2:0] sel);
        bit release_now;
        dflt_valid = dv; dflt_spec = ds; dflt_va = va;
        dflt_opcode = op; dflt_ra = ra; dflt_flags = fl;
        iflt_valid = iv; iflt_spec = is; iflt_pc = pc;
        csr_rd_en = en; csr_rd_sel = sel;
        release_now = en && (sel == 3'd0);
        if (dv && !ds && (!m_lock || release_now)) begin
            m_dva   = va;
            m_dstat = VA_W'({op, ra, fl});
            m_dfmt  = fmt_of(dpte_base, va);
            m_lock  = 1'b1;
        end else if (release_now) begin
            m_lock = 1'b0;
        end
        if (iv && !is) begin
            m_itag = pc;
            m_ifmt = fmt_of(ipte_base, pc);
        end
        @(posedge clk); #1;
        dflt_valid = 1'b0; iflt_valid = 1'b0; csr_rd_en = 1'b0;
        peek_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        dflt_valid = 0; dflt_spec = 0; dflt_va = '0; dflt_opcode = '0; dflt_ra = '0;
        dflt_flags = '0; dpte_base = 20'hA0003; iflt_valid = 0; iflt_spec = 0;
        iflt_pc = '0; ipte_base = 20'h50004; csr_rd_en = 0; csr_rd_sel = '0;
        m_dva = '0; m_dstat = '0; m_dfmt = '0; m_itag = '0; m_ifmt = '0; m_lock = 0;
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        peek_all();
        rst_n = 1'b1;
        @(posedge clk); #1;

        // sweep of fault, speculation and read patterns
        for (int k = 0; k < 96; k++) begin
            dpte_base = 20'hA0000 | VA_W'(k % 8);
            ipte_base = 20'h50000 | VA_W'((k * 3) % 8);
            apply((k % 7) != 6, (k % 5) == 3, VA_W'(k * 24'h1357 + 7),
                  6'((k * 11) % 64), 5'((k * 7) % 32), 6'((k * 37) % 64),
                  (k % 3) != 2, (k % 4) == 1, VA_W'(k * 24'h2A3B + 3),
                  (k % 3) == 0, ((k % 6) == 0) ? 3'd0 : 3'd1);
        end

        // directed lock sequence
        apply(0, 0, '0, 0, 0, 0, 0, 0, '0, 1, 3'd0);            // R6 release
        apply(1, 0, 20'h12345, 6'h3F, 5'h1F, 6'h3F, 0, 0, '0, 0, 3'd0); // R2 capture
        apply(1, 0, 20'hFEDCB, 6'h01, 5'h02, 6'h04, 0, 0, '0, 0, 3'd0); // R5 dropped
        apply(0, 0, '0, 0, 0, 0, 0, 0, '0, 1, 3'd2);            // R6 other read
        apply(1, 0, 20'h0BEEF, 6'h2A, 5'h15, 6'h11, 0, 0, '0, 1, 3'd0); // R7 recapture
        apply(0, 0, '0, 0, 0, 0, 0, 0, '0, 1, 3'd0);            // R6 release
        apply(1, 1, 20'h77777, 6'h05, 5'h05, 6'h05, 1, 1, 20'h33333, 0, 3'd0); // R8
        apply(0, 0, '0, 0, 0, 0, 1, 0, 20'h44444, 0, 3'd0);     // R9 no lock
        apply(0, 0, '0, 0, 0, 0, 1, 0, 20'h45678, 0, 3'd0);     // R9 overwrite

        // R10: unused selector codes read zero
        for (int s = 5; s < 8; s++) begin
            csr_rd_sel = 3'(s); #1;
            chk("R10 unused select", csr_rd_data, '0);
        end

        // R1: reset again clears everything
        rst_n = 1'b0; #1;
        m_dva = '0; m_dstat = '0; m_dfmt = '0; m_itag = '0; m_ifmt = '0; m_lock = 0;
        peek_all();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule